// File: doc/BRIEF.md
# I2C Register-Mapped 24-Line Port Expander

This block is an I2C target that gives a bus controller access to 24 general-purpose I/O lines grouped as three 8-bit ports. It watches the SCL and SDA lines, which arrive already synchronous to the block clock. It answers to one 7-bit address, acknowledges the bytes it accepts, and keeps a command byte. That byte steers every following data byte to one port of one of four register banks: input, output, polarity inversion and direction.

A controller writes the command byte after the address in a write transaction. The data bytes that follow in the same transaction update the selected register. To read, the controller sets the command in a write transaction, then issues a repeated start and the address with the read bit set. The block returns bytes from the selected register, MSB first, for as long as the controller acknowledges them. With auto-increment set in the command, the port index steps 0, 1, 2, 0 after each data byte, in both directions.

The bus state machine has these states:
- `ST_IDLE`: after reset or a stop condition.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_CMD` and `ST_CMD_ACK`: receiving and acknowledging the command byte.
- `ST_WR` and `ST_WR_ACK`: receiving and acknowledging data bytes.
- `ST_RD` and `ST_RD_ACK`: sending a data byte, then sampling the controller's acknowledge.
- `ST_IGNORE`: the bus is ignored until the next start.

The transitions are:
- A start condition leads to `ST_ADDR` from any state.
- A stop condition leads to `ST_IDLE` from any state.
- After the eighth address bit, the block goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- After the address acknowledge, the block goes to `ST_RD` for a read and to `ST_CMD` for a write.
- After each acknowledge of a received byte, the block goes to `ST_WR`.
- After the eighth bit sent, the block goes to `ST_RD_ACK`.
- After `ST_RD_ACK`, the block goes to `ST_RD` when the controller acknowledges and to `ST_IGNORE` when it does not.

Top module: `ioexp_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 0b010001 followed by the `addr_sel` level, so it answers to 0x22 with the strap low and to 0x23 with the strap high. The address byte's LSB is the direction: 1 selects a read and 0 selects a write.
- R2: The block does not acknowledge an address byte that does not match. Until the next start condition, it drives no SDA low and changes no register.
- R3: In a write transaction, the first byte after the address is the command. Command bits [1:0] select the port, and the value 3 acts as port 0. Bits [3:2] select the bank: 00 input, 01 output, 10 polarity, 11 direction. Bit 7 enables auto-increment.
- R4: Bytes written to the output bank of port p appear on `pin_out[8p+7:8p]`, with bit 7 as the MSB. All output bits reset to 1.
- R5: Bytes written to the direction bank of port p appear on `pin_is_input[8p+7:8p]`. A 1 means the pin is an input, and all bits reset to 1.
- R6: A read of the input bank returns the `pin_in` byte XOR the polarity register of that port. Polarity resets to 0.
- R7: Writes to the input bank are acknowledged and change no register.
- R8: A read returns the register selected by the last stored command, MSB first. It continues while the controller acknowledges and ends at its NACK. Without auto-increment, the same register is repeated.
- R9: With auto-increment set, the port index advances 0, 1, 2, 0 after every data byte written or read.
- R10: A start or stop condition inside a byte abandons that byte without a register update. A start returns the block to address matching.
- R11: The block drives SDA low during the ninth clock of every address, command and write-data byte it accepts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level, synchronous to clk |
| sda_i | input | 1 | Bus data level, synchronous to clk |
| addr_sel | input | 1 | Strap giving the address LSB |
| pin_in | input | NPORT*8 | Pin levels read by the input bank |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| pin_out | output | NPORT*8 | Output register contents |
| pin_is_input | output | NPORT*8 | Direction register; 1 = pin is an input |

## Verification
The assertions assume a well-formed bus:
- SDA changes only while SCL is low, except for start and stop conditions.
- Each SCL level is held for several block clocks, so every edge is seen once.
- `pin_in` does not move during a read byte.

The bench's bit-level tasks hold each SCL quarter period for four clocks and change the controller's SDA only in the low phase. Randomised traffic draws only well-formed commands, ports and byte counts. Malformed cases such as a wrong address, port value 3 and a byte cut off by a stop are reached only through directed sequences.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
        ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_IGNORE
    } bus_state_e;

    typedef enum logic [1:0] {
        BK_IN  = 2'b00,
        BK_OUT = 2'b01,
        BK_POL = 2'b10,
        BK_CFG = 2'b11
    } bank_e;
endpackage

// File: rtl/ioexp_line_sense.sv
module ioexp_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            scl_p <= 1'b1;
            sda_s <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl_i;
            scl_p <= scl_q;
            sda_s <= sda_i;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_q & ~scl_p;
    assign scl_fall  = ~scl_q & scl_p;
    assign start_det = scl_q & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_q & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ioexp_banks.sv
module ioexp_banks
    import ioexp_pkg::*;
#(
    parameter int NPORT = 3,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int NB = NPORT * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  bank_e         wr_bank,
    input  logic [PW-1:0] wr_port,
    input  logic [7:0]    wr_data,
    input  bank_e         rd_bank,
    input  logic [PW-1:0] rd_port,
    input  logic [NB-1:0] pin_in,
    output logic [7:0]    rd_data,
    output logic [NB-1:0] pin_out,
    output logic [NB-1:0] pin_is_input
);
    logic [7:0]    out_r [NPORT];
    logic [7:0]    pol_r [NPORT];
    logic [7:0]    cfg_r [NPORT];
    logic [NB-1:0] pol_flat;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_r[g] <= '1;
                pol_r[g] <= '0;
                cfg_r[g] <= '1;
            end else if (wr_en && int'(wr_port) == g) begin
                case (wr_bank)
                    BK_OUT:  out_r[g] <= wr_data;
                    BK_POL:  pol_r[g] <= wr_data;
                    BK_CFG:  cfg_r[g] <= wr_data;
                    default: ;
                endcase
            end
        end
        assign pin_out[g*8 +: 8]      = out_r[g];
        assign pin_is_input[g*8 +: 8] = cfg_r[g];
        assign pol_flat[g*8 +: 8]     = pol_r[g];
    end

    always_comb begin
        unique case (rd_bank)
            BK_IN:  rd_data = pin_in[rd_port*8 +: 8] ^ pol_r[rd_port];
            BK_OUT: rd_data = out_r[rd_port];
            BK_POL: rd_data = pol_r[rd_port];
            BK_CFG: rd_data = cfg_r[rd_port];
        endcase
    end

    // R7: a write aimed at the input bank leaves every stored register unchanged
    p_in_bank_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bank == BK_IN) |=>
            ($stable(pin_out) && $stable(pin_is_input) && $stable(pol_flat)));
endmodule

// File: rtl/ioexp_i2c_target.sv
module ioexp_i2c_target
    import ioexp_pkg::*;
#(
    parameter int          NPORT   = 3,
    parameter logic [5:0]  ADDR_HI = 6'b010001,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int NB = NPORT * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          addr_sel,
    input  logic [NB-1:0] pin_in,
    output logic          sda_oe,
    output logic [NB-1:0] pin_out,
    output logic [NB-1:0] pin_is_input
);
    bus_state_e    state;
    logic [3:0]    bit_cnt;
    logic [7:0]    shreg, txreg;
    logic          rw, ctl_nack;
    logic [PW-1:0] cmd_port, port_sel, next_port, rd_port;
    bank_e         cmd_bank;
    logic          cmd_ai;
    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          addr_hit, byte_in_done, wr_en;
    logic [7:0]    rd_data;

    ioexp_line_sense i_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign port_sel     = (int'(cmd_port) >= NPORT) ? '0 : cmd_port;
    assign next_port    = (int'(port_sel) == NPORT - 1) ? '0 : port_sel + PW'(1);
    assign rd_port      = (state == ST_RD_ACK && cmd_ai) ? next_port : port_sel;
    assign addr_hit     = (shreg[7:1] == {ADDR_HI, addr_sel});
    assign byte_in_done = scl_fall && (bit_cnt == 4'd8);
    assign wr_en        = (state == ST_WR) && byte_in_done && !start_det && !stop_det;

    ioexp_banks #(.NPORT(NPORT)) i_banks (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(cmd_bank), .wr_port(port_sel), .wr_data(shreg),
        .rd_bank(cmd_bank), .rd_port(rd_port), .pin_in(pin_in),
        .rd_data(rd_data), .pin_out(pin_out), .pin_is_input(pin_is_input)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            txreg    <= '0;
            rw       <= 1'b0;
            ctl_nack <= 1'b0;
            cmd_port <= '0;
            cmd_bank <= BK_IN;
            cmd_ai   <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR, ST_CMD, ST_WR: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_in_done) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            rw    <= shreg[0];
                            state <= addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                        end else if (state == ST_CMD) begin
                            cmd_port <= shreg[PW-1:0];
                            cmd_bank <= bank_e'(shreg[3:2]);
                            cmd_ai   <= shreg[7];
                            state    <= ST_CMD_ACK;
                        end else begin
                            if (cmd_ai) cmd_port <= next_port;
                            state <= ST_WR_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    if (rw) begin
                        state <= ST_RD;
                        txreg <= rd_data;
                    end else begin
                        state <= ST_CMD;
                    end
                end
                ST_CMD_ACK, ST_WR_ACK: if (scl_fall) state <= ST_WR;
                ST_RD: if (scl_fall) begin
                    if (bit_cnt == 4'd7) begin
                        bit_cnt <= '0;
                        state   <= ST_RD_ACK;
                    end else begin
                        txreg   <= {txreg[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ctl_nack <= sda_s;
                    end else if (scl_fall) begin
                        if (ctl_nack) begin
                            state <= ST_IGNORE;
                        end else begin
                            state <= ST_RD;
                            txreg <= rd_data;
                            if (cmd_ai) cmd_port <= next_port;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:                              sda_oe = ~txreg[7];
            default:                            sda_oe = 1'b0;
        endcase
    end

    // R10: a start condition always leads back to address matching
    p_start_to_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));
    // R10: a stop condition returns to idle with SDA released
    p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));
    // R2: while ignoring the bus nothing is driven and nothing is written
    p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !wr_en));
    // R8: SDA is left to the controller during its acknowledge slot
    p_rd_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK) |-> !sda_oe);
endmodule

// File: tb/test_ioexp_i2c_target.sv
module test_ioexp_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;
    localparam int NPORT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic [23:0] pin_in = 24'h0;
    logic        sda_oe;
    logic [23:0] pin_out, pin_is_input;
    logic        sda_line;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_out [3];
    logic [7:0] m_pol [3];
    logic [7:0] m_cfg [3];
    int         m_bank, m_port;
    bit         m_ai;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ioexp_i2c_target i_ioexp_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel(addr_sel), .pin_in(pin_in), .sda_oe(sda_oe),
        .pin_out(pin_out), .pin_is_input(pin_is_input)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(last);
    endtask

    function automatic int norm_port(input logic [1:0] p);
        return (p == 2'd3) ? 0 : int'(p);
    endfunction

    function automatic logic [7:0] exp_read(input int bank, input int port);
        case (bank)
            0: return pin_in[port*8 +: 8] ^ m_pol[port];
            1: return m_out[port];
            2: return m_pol[port];
            default: return m_cfg[port];
        endcase
    endfunction

    task automatic model_cmd(input logic [7:0] c);
        m_port = norm_port(c[1:0]);
        m_bank = int'(c[3:2]);
        m_ai   = c[7];
    endtask

    task automatic model_advance();
        if (m_ai) m_port = (m_port == NPORT - 1) ? 0 : m_port + 1;
    endtask

    // write transaction: address (write), command, n data bytes
    task automatic wr_txn(input logic [6:0] a, input logic [7:0] c, input int n,
                          input logic [31:0] data, input bit upd, output bit addr_ack);
        bit ack;
        bus_start();
        send_byte({a, 1'b0}, addr_ack);
        if (addr_ack) begin
            send_byte(c, ack);
            chk(ack, "R11 command ack", ack, 1);
            if (upd) model_cmd(c);
            for (int i = 0; i < n; i++) begin
                send_byte(data[i*8 +: 8], ack);
                chk(ack, "R11 data ack", ack, 1);
                if (upd) begin
                    case (m_bank)
                        1: m_out[m_port] = data[i*8 +: 8];
                        2: m_pol[m_port] = data[i*8 +: 8];
                        3: m_cfg[m_port] = data[i*8 +: 8];
                        default: ;
                    endcase
                    model_advance();
                end
            end
        end
        bus_stop();
    endtask

    // set pointer, repeated start, read n bytes, checking each against the model
    task automatic rd_txn(input logic [7:0] c, input int n, input string req);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'h44, ack);
        send_byte(c, ack);
        model_cmd(c);
        bus_start();
        send_byte(8'h45, ack);
        chk(ack, "R1 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            chk(d == exp_read(m_bank, m_port), req, d, exp_read(m_bank, m_port));
            model_advance();
        end
        bus_stop();
    endtask

    task automatic chk_pins(input string req);
        logic [23:0] eo, ec;
        eo = {m_out[2], m_out[1], m_out[0]};
        ec = {m_cfg[2], m_cfg[1], m_cfg[0]};
        chk(pin_out == eo, req, pin_out, eo);
        chk(pin_is_input == ec, req, pin_is_input, ec);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        void'($urandom(32'd1234));
        for (int p = 0; p < 3; p++) begin
            m_out[p] = 8'hFF; m_pol[p] = 8'h00; m_cfg[p] = 8'hFF;
        end
        m_bank = 0; m_port = 0; m_ai = 1'b0;
        pin_in = 24'hA5_3C_0F;
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // reset state: R4, R5, R6
        chk(pin_out == 24'hFFFFFF, "R4 reset output ones", pin_out, 24'hFFFFFF);
        chk(pin_is_input == 24'hFFFFFF, "R5 reset all inputs", pin_is_input, 24'hFFFFFF);
        chk(sda_oe == 1'b0, "R11 SDA released at reset", sda_oe, 0);
        rd_txn(8'h08, 1, "R6 polarity reset to zero");

        // R1: strap low answers to 0x22; R4 output write
        wr_txn(7'h22, 8'h01, 1, 32'h5A, 1'b1, ack);
        chk(ack, "R1 address 0x22 ack", ack, 1);
        chk_pins("R4 output port 1");

        // R1/R2: strap high answers to 0x23, not 0x22
        addr_sel = 1'b1;
        wq(2);
        wr_txn(7'h22, 8'h00, 1, 32'h00, 1'b0, ack);
        chk(!ack, "R2 wrong address NACK", ack, 0);
        // R2: bytes after a NACKed address change nothing
        bus_start();
        send_byte(8'h44, ack);
        chk(!ack, "R2 NACK strap high", ack, 0);
        send_byte(8'h04, ack);
        chk(!ack, "R2 ignored command not acked", ack, 0);
        send_byte(8'h00, ack);
        bus_stop();
        chk_pins("R2 no change after mismatch");
        wr_txn(7'h23, 8'h06, 1, 32'h3C, 1'b1, ack);
        chk(ack, "R1 address 0x23 ack", ack, 1);
        chk_pins("R3 output port 2");
        addr_sel = 1'b0;
        wq(2);

        // R3: port value 3 acts as port 0
        wr_txn(7'h22, 8'h07, 1, 32'hC3, 1'b1, ack);
        chk(pin_out[7:0] == 8'hC3, "R3 port 3 maps to port 0", pin_out[7:0], 8'hC3);

        // R5: direction write
        wr_txn(7'h22, 8'h0D, 1, 32'h0F, 1'b1, ack);
        chk(pin_is_input[15:8] == 8'h0F, "R5 direction port 1", pin_is_input[15:8], 8'h0F);

        // R7: input bank write acknowledged and ignored
        wr_txn(7'h22, 8'h00, 2, 32'h1234, 1'b1, ack);
        chk_pins("R7 input bank write ignored");
        rd_txn(8'h80, 3, "R7 input read unchanged after write");

        // R6: polarity applied to input reads
        wr_txn(7'h22, 8'h0A, 1, 32'hFF, 1'b1, ack);
        rd_txn(8'h02, 1, "R6 input XOR polarity");

        // R9: auto-increment wraps 1,2,0,1
        wr_txn(7'h22, 8'h85, 4, 32'h44_33_22_11, 1'b1, ack);
        chk_pins("R9 auto-increment write wrap");
        rd_txn(8'h86, 4, "R9 auto-increment read wrap");
        // R8: no auto-increment repeats the same register
        rd_txn(8'h05, 3, "R8 repeated read same register");

        // R10: stop inside a data byte does not write
        bus_start();
        send_byte(8'h44, ack);
        send_byte(8'h04, ack);
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        bus_stop();
        chk_pins("R10 stop aborts byte");
        // R10: start inside a data byte returns to address match
        bus_start();
        send_byte(8'h44, ack);
        send_byte(8'h04, ack);
        for (int i = 0; i < 3; i++) bit_out(1'b1);
        bus_start();
        send_byte(8'h44, ack);
        chk(ack, "R10 start inside byte re-matches", ack, 1);
        bus_stop();
        chk_pins("R10 start aborts byte");

        // R8: NACK ends read, further clocks ignored
        bus_start();
        send_byte(8'h45, ack);
        recv_byte(1'b1, d);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R8 SDA released after controller NACK", d, 8'hFF);
        bus_stop();

        // random traffic
        for (int t = 0; t < 30; t++) begin
            logic [7:0] c;
            int n;
            pin_in = 24'($urandom);
            c = {1'($urandom), 3'b000, 2'($urandom), 2'($urandom % 3)};
            n = 1 + int'($urandom % 3);
            if ($urandom % 2 == 0) begin
                wr_txn(7'h22, c, n, $urandom, 1'b1, ack);
                chk(ack, "R1 random write ack", ack, 1);
                chk_pins("R4 R5 random write");
            end else begin
                rd_txn(c, n, "R8 random read");
            end
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule